// File: doc/BRIEF.md
# SPI Serial EEPROM Slave Front-End

This block is the slave side of a byte-addressed serial EEPROM on an SPI bus. A host selects it by driving chip select low, clocks in an 8-bit command and, for memory commands, a 16-bit address, and then either streams data out of the array or streams data in for a page write. An internal byte array holds the contents. A status byte reports a busy flag, the write-enable latch and a two-bit block-protection field. A programmable cycle counter stands in for the internal programming time. The array depth is set by a parameter; the default is 2 KiB, and setting `ADDR_W` to 13 gives the full 8 KiB.

The SPI pins are oversampled by the system clock. SI is taken on each rising SCK edge. SO changes on each falling SCK edge, so both clock polarities that idle low (mode 0) and idle high (mode 3) work. SO comes with an output-enable, so that the pin can be tri-stated at the pad.

Top module: `eeprom_spi_slave`

## Requirements
- R1: Each fall of `cs_n` starts a new frame at the opcode phase. A rise of `cs_n` ends the frame at once, even partway through an opcode or an address.
- R2: Opcode 8'h03 is a read. It is followed by a 16-bit address, sent MSB first, of which only the low `ADDR_W` bits are used and the rest are ignored.
- R3: After the address of a read, the byte at that address appears on `so` MSB first. Each further 8 clocks give the byte at the next address.
- R4: A sequential read that passes the top address (2^ADDR_W − 1) continues at address 0.
- R5: Opcode 8'h05 returns the status byte MSB first: bit 0 busy, bit 1 write-enable latch, bits 3:2 protection field, bits 7:4 zero. It is accepted while busy.
- R6: `so_oe` is 0 while `cs_n` is high and during the opcode and address phases. It goes to 1 on the first falling SCK edge of the data-out phase.
- R7: The write-enable latch is 0 after reset. Opcode 8'h06 sets it only when `cs_n` then rises. Any bits that follow 8'h06 in the same frame write nothing.
- R8: Opcode 8'h02 plus a 16-bit address starts a page write. Bytes land at successive addresses inside one 32-byte page and wrap within that page. They are committed when `cs_n` rises, and only if the latch is set, at least one whole byte was sent and no partial byte is pending.
- R9: Opcode 8'h01 with one data byte, under the latch, loads status bits 3:2 from bits 3:2 of that byte. The protection field values 0, 1, 2 and 3 guard no address, the top quarter, the top half and the whole array. A write whose page lies in the guarded range is dropped and starts no busy period.
- R10: A committed write or status write sets busy for `BUSY_CYCLES` clock cycles. Busy and the latch then clear together. While busy, read, write, status-write and write-enable opcodes are ignored and SO is never enabled for them.
- R11: All of the above works with SCK idling low (mode 0) and with SCK idling high (mode 3).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the SPI pins |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Chip select, active low |
| sck | input | 1 | SPI serial clock |
| si | input | 1 | Serial data from the host |
| so | output | 1 | Serial data to the host |
| so_oe | output | 1 | Output-enable for the SO pad driver |

## Verification
The hardest conditions to reach from the pins are the ones where a write must not happen even though a frame looks like a write. These are a write opcode that follows the enable opcode in the same frame, a frame that ends three bits into a byte, and a page that lies in the guarded quarter. For each of these the bench first stores a known value through a legitimate write. It then sends the rejected frame, reads the status to confirm that no busy period began, and reads the location back to show that the old value is still there. The busy window is stretched by a parameter, so that a status read and a full read frame both fit inside one programming period.

// File: rtl/eeprom_pkg.sv
package eeprom_pkg;

    localparam logic [7:0] OP_SETPROT = 8'h01;
    localparam logic [7:0] OP_WRITE   = 8'h02;
    localparam logic [7:0] OP_READ    = 8'h03;
    localparam logic [7:0] OP_STATUS  = 8'h05;
    localparam logic [7:0] OP_ENABLE  = 8'h06;

    typedef enum logic [2:0] {
        PH_OPCODE,
        PH_ADDR,
        PH_WDATA,
        PH_PDATA,
        PH_RDOUT,
        PH_STOUT,
        PH_SKIP
    } phase_e;

    typedef struct packed {
        logic [3:0] zero;
        logic [1:0] guard;
        logic       wel;
        logic       busy;
    } status_t;

    typedef struct packed {
        logic active;
        logic start;
        logic stop;
        logic rise;
        logic fall;
        logic mosi;
    } pin_ev_t;

    function automatic logic in_guarded(input logic [1:0] guard,
                                        input logic       top1,
                                        input logic       top2);
        case (guard)
            2'd0:    return 1'b0;
            2'd1:    return top1 & top2;
            2'd2:    return top1;
            default: return 1'b1;
        endcase
    endfunction

endpackage

// File: rtl/eeprom_pin_sync.sv
module eeprom_pin_sync
    import eeprom_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    cs_n,
    input  logic    sck,
    input  logic    si,
    output pin_ev_t ev
);
    logic [2:0] cs_q;
    logic [2:0] sck_q;
    logic [1:0] si_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cs_q  <= 3'b111;
            sck_q <= 3'b000;
            si_q  <= 2'b00;
        end else begin
            cs_q  <= {cs_q[1:0], cs_n};
            sck_q <= {sck_q[1:0], sck};
            si_q  <= {si_q[0], si};
        end
    end

    assign ev.active = !cs_q[1];
    assign ev.start  = !cs_q[1] &&  cs_q[2];
    assign ev.stop   =  cs_q[1] && !cs_q[2];
    assign ev.rise   =  sck_q[1] && !sck_q[2];
    assign ev.fall   = !sck_q[1] &&  sck_q[2];
    assign ev.mosi   =  si_q[1];

endmodule

// File: rtl/eeprom_busy_timer.sv
module eeprom_busy_timer #(
    parameter int CYCLES = 200
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    output logic busy,
    output logic done
);
    localparam int CW = $clog2(CYCLES + 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy <= 1'b0;
            cnt  <= '0;
        end else if (start) begin
            busy <= 1'b1;
            cnt  <= CW'(CYCLES - 1);
        end else if (busy) begin
            if (cnt == '0) busy <= 1'b0;
            else           cnt  <= cnt - 1'b1;
        end
    end

    assign done = busy && (cnt == '0);

endmodule

// File: rtl/eeprom_array.sv
module eeprom_array #(
    parameter int AW = 11,
    parameter int PW = 5
) (
    input  logic                   clk,
    input  logic                   wr_en,
    input  logic [AW-PW-1:0]       wr_page,
    input  logic [(1<<PW)-1:0]     wr_mask,
    input  logic [(1<<PW)*8-1:0]   wr_data,
    input  logic [AW-1:0]          rd_addr,
    output logic [7:0]             rd_data
);
    localparam int DEPTH = 1 << AW;
    localparam int PAGE  = 1 << PW;

    logic [7:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            for (int i = 0; i < PAGE; i++) begin
                if (wr_mask[i]) mem[{wr_page, PW'(i)}] <= wr_data[i*8 +: 8];
            end
        end
    end

    assign rd_data = mem[rd_addr];

endmodule

// File: rtl/eeprom_frame_ctrl.sv
module eeprom_frame_ctrl
    import eeprom_pkg::*;
#(
    parameter int AW = 11,
    parameter int PW = 5
) (
    input  logic                 clk,
    input  logic                 rst,
    input  pin_ev_t              ev,
    input  logic                 busy,
    input  logic                 done,
    input  logic [7:0]           rd_data,
    output logic [AW-1:0]        rd_addr,
    output logic                 wr_en,
    output logic [AW-PW-1:0]     wr_page,
    output logic [(1<<PW)-1:0]   wr_mask,
    output logic [(1<<PW)*8-1:0] wr_data,
    output logic                 timer_start,
    output logic                 wel_o,
    output logic                 so,
    output logic                 so_oe
);
    localparam int PAGE = 1 << PW;

    phase_e                 phase;
    logic [15:0]            shreg;
    logic [15:0]            nxt;
    logic [4:0]             cnt;
    logic                   is_wr;
    logic                   wren_seen;
    logic [AW-1:0]          ptr;
    logic [PAGE-1:0][7:0]   pbuf;
    logic [PAGE-1:0]        pmask;
    logic [1:0]             prot_val;
    logic                   prot_got;
    logic [7:0]             out_sh;
    logic [2:0]             out_n;
    logic                   so_q;
    logic                   oe_q;
    logic                   wel;
    logic [1:0]             guard;
    status_t                stat;
    logic [7:0]             out_byte;
    logic                   commit_wr;
    logic                   commit_prot;

    assign nxt  = {shreg[14:0], ev.mosi};
    assign stat = '{zero: 4'd0, guard: guard, wel: wel, busy: busy};
    assign out_byte = (phase == PH_RDOUT) ? rd_data : stat;

    assign commit_wr   = ev.stop && phase == PH_WDATA && cnt[2:0] == 3'd0 &&
                         |pmask && wel && !busy &&
                         !in_guarded(guard, ptr[AW-1], ptr[AW-2]);
    assign commit_prot = ev.stop && phase == PH_PDATA && cnt[2:0] == 3'd0 &&
                         prot_got && wel && !busy;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase     <= PH_SKIP;
            shreg     <= '0;
            cnt       <= '0;
            is_wr     <= 1'b0;
            wren_seen <= 1'b0;
            ptr       <= '0;
            pbuf      <= '0;
            pmask     <= '0;
            prot_val  <= '0;
            prot_got  <= 1'b0;
            out_sh    <= '0;
            out_n     <= '0;
            so_q      <= 1'b0;
            oe_q      <= 1'b0;
            wel       <= 1'b0;
            guard     <= '0;
        end else begin
            if (done) wel <= 1'b0;
            if (ev.start) begin
                phase     <= PH_OPCODE;
                cnt       <= '0;
                wren_seen <= 1'b0;
                pmask     <= '0;
                prot_got  <= 1'b0;
                out_n     <= '0;
                oe_q      <= 1'b0;
            end else if (ev.stop) begin
                oe_q  <= 1'b0;
                phase <= PH_SKIP;
                if (wren_seen)   wel   <= 1'b1;
                if (commit_prot) guard <= prot_val;
            end else if (ev.active && ev.rise) begin
                shreg <= nxt;
                case (phase)
                    PH_OPCODE: begin
                        if (cnt == 5'd7) begin
                            cnt <= '0;
                            case (nxt[7:0])
                                OP_STATUS: phase <= PH_STOUT;
                                OP_READ: begin
                                    phase <= busy ? PH_SKIP : PH_ADDR;
                                    is_wr <= 1'b0;
                                end
                                OP_WRITE: begin
                                    phase <= busy ? PH_SKIP : PH_ADDR;
                                    is_wr <= 1'b1;
                                end
                                OP_SETPROT: phase <= busy ? PH_SKIP : PH_PDATA;
                                OP_ENABLE: begin
                                    wren_seen <= !busy;
                                    phase     <= PH_SKIP;
                                end
                                default: phase <= PH_SKIP;
                            endcase
                        end else begin
                            cnt <= cnt + 5'd1;
                        end
                    end
                    PH_ADDR: begin
                        if (cnt == 5'd15) begin
                            cnt   <= '0;
                            ptr   <= nxt[AW-1:0];
                            phase <= is_wr ? PH_WDATA : PH_RDOUT;
                        end else begin
                            cnt <= cnt + 5'd1;
                        end
                    end
                    PH_WDATA: begin
                        cnt <= {2'b00, cnt[2:0] + 3'd1};
                        if (cnt[2:0] == 3'd7) begin
                            pbuf[ptr[PW-1:0]]  <= nxt[7:0];
                            pmask[ptr[PW-1:0]] <= 1'b1;
                            ptr <= {ptr[AW-1:PW], ptr[PW-1:0] + 1'b1};
                        end
                    end
                    PH_PDATA: begin
                        cnt <= {2'b00, cnt[2:0] + 3'd1};
                        if (cnt[2:0] == 3'd7 && !prot_got) begin
                            prot_val <= nxt[3:2];
                            prot_got <= 1'b1;
                        end
                    end
                    default: ;
                endcase
            end else if (ev.active && ev.fall &&
                         (phase == PH_RDOUT || phase == PH_STOUT)) begin
                out_n <= out_n + 3'd1;
                if (out_n == 3'd0) begin
                    so_q   <= out_byte[7];
                    out_sh <= {out_byte[6:0], 1'b0};
                    oe_q   <= 1'b1;
                    if (phase == PH_RDOUT) ptr <= ptr + 1'b1;
                end else begin
                    so_q   <= out_sh[7];
                    out_sh <= {out_sh[6:0], 1'b0};
                end
            end
        end
    end

    assign rd_addr     = ptr;
    assign wr_en       = commit_wr;
    assign wr_page     = ptr[AW-1:PW];
    assign wr_mask     = pmask;
    assign wr_data     = pbuf;
    assign timer_start = commit_wr || commit_prot;
    assign wel_o       = wel;
    assign so          = so_q;
    assign so_oe       = oe_q;

    AST_HIZ_WHEN_DESELECTED: assert property (@(posedge clk) disable iff (rst)
        !ev.active |=> !oe_q);                                        // R6
    AST_HIZ_IN_CMD_PHASE: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_OPCODE || phase == PH_ADDR) |-> !oe_q);          // R6
    AST_WEL_SET_ON_DESELECT: assert property (@(posedge clk) disable iff (rst)
        $rose(wel) |-> $past(ev.stop));                               // R7
    AST_PAGE_HELD_IN_WRITE: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_WDATA && $past(phase) == PH_WDATA)
        |-> ptr[AW-1:PW] == $past(ptr[AW-1:PW]));                     // R8

endmodule

// File: rtl/eeprom_spi_slave.sv
module eeprom_spi_slave
    import eeprom_pkg::*;
#(
    parameter int ADDR_W      = 11,
    parameter int PAGE_W      = 5,
    parameter int BUSY_CYCLES = 200
) (
    input  logic clk,
    input  logic rst,
    input  logic cs_n,
    input  logic sck,
    input  logic si,
    output logic so,
    output logic so_oe
);
    localparam int PAGE = 1 << PAGE_W;

    pin_ev_t                  ev;
    logic                     busy;
    logic                     done;
    logic                     timer_start;
    logic                     wel;
    logic                     wr_en;
    logic [ADDR_W-PAGE_W-1:0] wr_page;
    logic [PAGE-1:0]          wr_mask;
    logic [PAGE*8-1:0]        wr_data;
    logic [ADDR_W-1:0]        rd_addr;
    logic [7:0]               rd_data;

    eeprom_pin_sync u_pins (
        .clk  (clk),
        .rst  (rst),
        .cs_n (cs_n),
        .sck  (sck),
        .si   (si),
        .ev   (ev)
    );

    eeprom_busy_timer #(.CYCLES(BUSY_CYCLES)) u_timer (
        .clk   (clk),
        .rst   (rst),
        .start (timer_start),
        .busy  (busy),
        .done  (done)
    );

    eeprom_array #(.AW(ADDR_W), .PW(PAGE_W)) u_array (
        .clk     (clk),
        .wr_en   (wr_en),
        .wr_page (wr_page),
        .wr_mask (wr_mask),
        .wr_data (wr_data),
        .rd_addr (rd_addr),
        .rd_data (rd_data)
    );

    eeprom_frame_ctrl #(.AW(ADDR_W), .PW(PAGE_W)) u_ctrl (
        .clk         (clk),
        .rst         (rst),
        .ev          (ev),
        .busy        (busy),
        .done        (done),
        .rd_data     (rd_data),
        .rd_addr     (rd_addr),
        .wr_en       (wr_en),
        .wr_page     (wr_page),
        .wr_mask     (wr_mask),
        .wr_data     (wr_data),
        .timer_start (timer_start),
        .wel_o       (wel),
        .so          (so),
        .so_oe       (so_oe)
    );

    AST_COMMIT_STARTS_BUSY: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> busy);                                              // R10
    AST_BUSY_END_CLEARS_WEL: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> !wel);                                        // R10

endmodule

// File: tb/eeprom_spi_slave_tb.sv
module eeprom_spi_slave_tb;

    localparam int H    = 8;
    localparam int BUSY = 3000;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cs_n = 1'b1;
    logic sck = 1'b0;
    logic si = 1'b0;
    logic so;
    logic so_oe;

    int   n_chk = 0;
    int   n_bad = 0;
    bit   mode3 = 1'b0;
    bit   finished = 1'b0;
    logic [7:0] wb [8];
    logic [7:0] rb [8];

    always #2 clk = ~clk;

    eeprom_spi_slave #(.ADDR_W(11), .PAGE_W(5), .BUSY_CYCLES(BUSY)) u_dut (
        .clk   (clk),
        .rst   (rst),
        .cs_n  (cs_n),
        .sck   (sck),
        .si    (si),
        .so    (so),
        .so_oe (so_oe)
    );

    task automatic wclk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic cs_lo();
        sck = mode3;
        wclk(H);
        cs_n = 1'b0;
        wclk(H);
    endtask

    task automatic cs_hi();
        wclk(H);
        cs_n = 1'b1;
        wclk(2 * H);
    endtask

    task automatic bit_x(input logic b, output logic o, output logic e);
        if (mode3) sck = 1'b0;
        si = b;
        wclk(H);
        o = so;
        e = so_oe;
        sck = 1'b1;
        wclk(H);
        if (!mode3) sck = 1'b0;
    endtask

    task automatic byte_x(input logic [7:0] b, output logic [7:0] o, output logic any_oe);
        logic e;
        any_oe = 1'b0;
        for (int i = 7; i >= 0; i--) begin
            bit_x(b[i], o[i], e);
            any_oe |= e;
        end
    endtask

    task automatic do_rdsr(output logic [7:0] st);
        logic [7:0] d;
        logic e;
        cs_lo();
        byte_x(8'h05, d, e);
        byte_x(8'h00, st, e);
        cs_hi();
    endtask

    task automatic do_wren();
        logic [7:0] d;
        logic e;
        cs_lo();
        byte_x(8'h06, d, e);
        cs_hi();
    endtask

    task automatic do_read(input logic [15:0] a, input int n,
                           output logic cmd_oe, output logic data_oe);
        logic [7:0] d;
        logic e;
        cs_lo();
        byte_x(8'h03, d, e);     cmd_oe = e;
        byte_x(a[15:8], d, e);   cmd_oe |= e;
        byte_x(a[7:0], d, e);    cmd_oe |= e;
        data_oe = 1'b0;
        for (int i = 0; i < n; i++) begin
            byte_x(8'h00, rb[i], e);
            data_oe |= e;
        end
        cs_hi();
    endtask

    task automatic do_write(input logic [15:0] a, input int n);
        logic [7:0] d;
        logic e;
        cs_lo();
        byte_x(8'h02, d, e);
        byte_x(a[15:8], d, e);
        byte_x(a[7:0], d, e);
        for (int i = 0; i < n; i++) byte_x(wb[i], d, e);
        cs_hi();
    endtask

    task automatic wait_idle();
        wclk(BUSY + 100);
    endtask

    task automatic t_reset();
        logic [7:0] st;
        chk("R6 so_oe after reset", so_oe, 0);
        do_rdsr(st);
        chk("R7 status after reset", st, 8'h00);
    endtask

    task automatic t_enable();
        logic [7:0] st;
        do_wren();
        do_rdsr(st);
        chk("R7 latch set after deselect", st, 8'h02);
    endtask

    task automatic t_write_read();
        logic [7:0] st;
        logic co, dox;
        wb[0] = 8'h11; wb[1] = 8'h22; wb[2] = 8'h33; wb[3] = 8'h44;
        do_write(16'hE123, 4);
        wait_idle();
        do_rdsr(st);
        chk("R10 busy and latch clear after write", st, 8'h00);
        do_read(16'h0123, 4, co, dox);
        chk("R6 no drive in command phases", co, 0);
        chk("R6 drive in data phase", dox, 1);
        chk("R3 byte 0", rb[0], 8'h11);
        chk("R3 byte 1", rb[1], 8'h22);
        chk("R3 byte 2", rb[2], 8'h33);
        chk("R3 byte 3", rb[3], 8'h44);
        do_read(16'hF125, 1, co, dox);
        chk("R2 upper address bits ignored", rb[0], 8'h33);
    endtask

    task automatic t_page_wrap();
        logic co, dox;
        do_wren();
        wb[0] = 8'hA1; wb[1] = 8'hA2; wb[2] = 8'hA3;
        do_write(16'h013E, 3);
        wait_idle();
        do_read(16'h013E, 2, co, dox);
        chk("R8 page byte 13E", rb[0], 8'hA1);
        chk("R8 page byte 13F", rb[1], 8'hA2);
        do_read(16'h0120, 1, co, dox);
        chk("R8 wrap to page start", rb[0], 8'hA3);
    endtask

    task automatic t_same_frame();
        logic [7:0] d, st;
        logic e, co, dox;
        cs_lo();
        byte_x(8'h06, d, e);
        byte_x(8'h02, d, e);
        byte_x(8'h01, d, e);
        byte_x(8'h23, d, e);
        byte_x(8'h99, d, e);
        cs_hi();
        do_rdsr(st);
        chk("R7 same-frame write starts no busy", st, 8'h02);
        do_read(16'h0123, 1, co, dox);
        chk("R7 same-frame write leaves array", rb[0], 8'h11);
    endtask

    task automatic t_partial_byte();
        logic [7:0] d, st;
        logic e, o, co, dox;
        cs_lo();
        byte_x(8'h02, d, e);
        byte_x(8'h01, d, e);
        byte_x(8'h23, d, e);
        byte_x(8'h5A, d, e);
        bit_x(1'b1, o, e);
        bit_x(1'b0, o, e);
        bit_x(1'b1, o, e);
        cs_hi();
        do_rdsr(st);
        chk("R8 partial byte starts no busy", st, 8'h02);
        do_read(16'h0123, 1, co, dox);
        chk("R8 partial byte frame not committed", rb[0], 8'h11);
    endtask

    task automatic t_top_wrap();
        logic co, dox;
        wb[0] = 8'hE1; wb[1] = 8'hE2;
        do_write(16'h07FE, 2);
        wait_idle();
        do_wren();
        wb[0] = 8'h0A;
        do_write(16'h0000, 1);
        wait_idle();
        do_read(16'h07FE, 3, co, dox);
        chk("R4 top-1 byte", rb[0], 8'hE1);
        chk("R4 top byte", rb[1], 8'hE2);
        chk("R4 wrap to address 0", rb[2], 8'h0A);
    endtask

    task automatic t_guard();
        logic [7:0] d, st;
        logic e, co, dox;
        do_wren();
        cs_lo();
        byte_x(8'h01, d, e);
        byte_x(8'h04, d, e);
        cs_hi();
        wait_idle();
        do_rdsr(st);
        chk("R9 protection field loaded", st, 8'h04);
        do_wren();
        wb[0] = 8'h77;
        do_write(16'h07FE, 1);
        do_rdsr(st);
        chk("R9 guarded write starts no busy", st, 8'h06);
        do_read(16'h07FE, 1, co, dox);
        chk("R9 guarded byte unchanged", rb[0], 8'hE1);
        wb[0] = 8'h0B;
        do_write(16'h0000, 1);
        wait_idle();
        do_read(16'h0000, 1, co, dox);
        chk("R9 unguarded write lands", rb[0], 8'h0B);
    endtask

    task automatic t_busy();
        logic [7:0] st;
        logic co, dox;
        do_wren();
        wb[0] = 8'h5C;
        do_write(16'h0010, 1);
        do_rdsr(st);
        chk("R5 status readable while busy", st, 8'h07);
        do_read(16'h0010, 2, co, dox);
        chk("R10 read ignored while busy", dox, 0);
        wait_idle();
        do_rdsr(st);
        chk("R10 busy end clears latch", st, 8'h04);
        do_read(16'h0010, 1, co, dox);
        chk("R10 busy-period write landed", rb[0], 8'h5C);
    endtask

    task automatic t_mode3();
        logic [7:0] st;
        logic co, dox;
        mode3 = 1'b1;
        do_read(16'h0123, 2, co, dox);
        chk("R11 mode 3 read byte 0", rb[0], 8'h11);
        chk("R11 mode 3 read byte 1", rb[1], 8'h22);
        do_rdsr(st);
        chk("R11 mode 3 status", st, 8'h04);
        do_wren();
        wb[0] = 8'h66;
        do_write(16'h0124, 1);
        wait_idle();
        do_read(16'h0124, 1, co, dox);
        chk("R11 mode 3 write", rb[0], 8'h66);
        mode3 = 1'b0;
    endtask

    task automatic t_abort();
        logic [7:0] d, st;
        logic e;
        cs_lo();
        byte_x(8'h03, d, e);
        byte_x(8'h01, d, e);
        cs_hi();
        chk("R1 SO released after abort", so_oe, 0);
        do_rdsr(st);
        chk("R1 next frame restarts at opcode", st, 8'h04);
    endtask

    initial begin
        wclk(5);
        rst = 1'b0;
        wclk(5);
        t_reset();
        t_enable();
        t_write_read();
        t_page_wrap();
        t_same_frame();
        t_partial_byte();
        t_top_wrap();
        t_guard();
        t_busy();
        t_mode3();
        t_abort();
        if (!finished) begin
            finished = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        wclk(190000);
        if (!finished) begin
            finished = 1'b1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

endmodule